// File: doc/BRIEF.md
# Virtual Group 0 Active-Priority Register Bank

This block keeps the Group 0 active-priority bitmap of a virtual interrupt controller interface. One bit stands for each preemption level. A set bit means an interrupt at that level is active and has not yet had its priority dropped. A clear bit means no interrupt at that level is active, or every active one at that level has already dropped. Depending on how many preemption bits the build supports (5, 6 or 7), the bank holds one, two or four registers of 32 levels each. Each register is 64 bits wide, and only the lower half is stored.

System-register accesses reach the block as a decoded request. The request carries the five encoding fields, the requesting exception level, the nested-virtualization control bits and the register-enable bits for EL2 and EL3. The block first checks the register index. It then routes the access to one of four results:
- a direct read or write of the bank,
- a redirect to a memory slot (the block reports the slot address),
- a trap (the block reports the target level and the exception class),
- an undefined-instruction result.

The block also reports, combinationally, the highest active priority. This is the lowest-numbered set bit across all implemented registers.

A two-state machine paces the responses:
- **ST_IDLE** means no response is shown.
- **ST_RESP** shows a response for one cycle.
- The **accept** transition, into ST_RESP, is taken on every clock edge at which a valid request matches the register encoding.
- The **release** transition, back to ST_IDLE, is taken on every edge without such a request.

Top module: `vapr_bank`

## Requirements
- R1: Each register reads back as 64 bits. Bits [63:32] always read zero, and the write data in those bits is discarded.
- R2: The number of implemented registers is 1 for PRE_BITS=5, 2 for PRE_BITS=6 and 4 for PRE_BITS=7. An access whose index m = op2[1:0] is not implemented gives the undefined outcome and changes no state. This index check comes before any exception-level check.
- R3: A request is accepted only when op0=2'b11, op1=3'b100, CRn=4'b1100, CRm=4'b1000 and op2[2]=0. For any other encoding, no response is produced and no state changes.
- R4: An access from EL0 (req_el=0) gives the undefined outcome.
- R5: An access from EL1 (req_el=1) is decided from the nested-virtualization bits req_nv[2:0], in this order:
  - If req_nv[2] and req_nv[0] are both 1, the outcome is redirect, with address 0x480 + 8*m.
  - Otherwise, if req_nv[0] is 1, the outcome is a trap to EL2 (rsp_trap_el=2).
  - Otherwise the outcome is undefined.
  - When EL2 is absent, an EL1 access is always undefined.
  - A redirect changes no register.
- R6: An access from EL2 (req_el=2) with sre_el2=0, or from EL3 (req_el=3) with sre_el3=0, traps to that same level and changes no register. With the enable bit set, the access reads or writes the indexed register directly. When EL2 is absent, an EL2 access is undefined.
- R7: When EL2 is absent (EL2_PRESENT=0), an enabled EL3 access gives the normal outcome. A read returns zero, and a write changes nothing.
- R8: After reset, all implemented registers are zero and top_valid is 0.
- R9: top_valid is 1 exactly when any implemented bit is set. top_level is then m*32 + bit of the lowest-numbered set bit. The output follows a write at the clock edge that performs the write.
- R10: A response appears at the clock edge after the request and lasts one cycle. The rsp_outcome encoding is:
  - 4'b0001 = normal
  - 4'b0010 = redirect
  - 4'b0100 = trap
  - 4'b1000 = undefined

  The other response fields are:
  - rsp_class is 0x18 on a trap and 0 otherwise.
  - rsp_trap_el is 0 unless the outcome is a trap.
  - rsp_redir_addr is 0 unless the outcome is a redirect.
  - rsp_rdata is 0 except for a normal read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2; bits [1:0] give index m |
| req_el | input | 2 | Exception level of the requester (0 to 3) |
| req_nv | input | 3 | Nested-virtualization control bits |
| sre_el2 | input | 1 | Register-enable bit for EL2 |
| sre_el3 | input | 1 | Register-enable bit for EL3 |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response shown this cycle |
| rsp_outcome | output | 4 | One-hot outcome code |
| rsp_rdata | output | 64 | Read data for a normal read |
| rsp_redir_addr | output | 12 | Memory slot address for a redirect |
| rsp_trap_el | output | 2 | Target level for a trap |
| rsp_class | output | 6 | Exception class for a trap |
| top_valid | output | 1 | At least one level is active |
| top_level | output | LVL_W | Highest active (lowest-numbered) level |

## Verification
Faults can show up in two ways:
- **Corrupted register contents.** These show at top_level the cycle after the faulty write, before any read. A read of the affected index exposes them in the next response.
- **A wrong routing decision.** This shows on the very next response as a wrong outcome code, address or target level.

Writes that take a redirect, trap or undefined path are checked by reading the same index back straight afterwards. Any leakage into the bank would then differ from the bench's shadow copy.

// File: rtl/vapr_pkg.sv
package vapr_pkg;

    typedef enum logic [3:0] {
        OUT_NORMAL = 4'b0001,
        OUT_REDIR  = 4'b0010,
        OUT_TRAP   = 4'b0100,
        OUT_UNDEF  = 4'b1000
    } outcome_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } state_e;

    localparam logic [5:0]  TRAP_CLASS = 6'h18;
    localparam logic [11:0] REDIR_BASE = 12'h480;

    typedef struct packed {
        outcome_e    outcome;
        logic [1:0]  trap_el;
        logic [11:0] redir_addr;
        logic        rd_en;
        logic        wr_en;
    } decision_t;

    function automatic int nreg_for(input int pre_bits);
        if (pre_bits >= 7)      return 4;
        else if (pre_bits == 6) return 2;
        else                    return 1;
    endfunction

endpackage

// File: rtl/vapr_access_decode.sv
module vapr_access_decode
    import vapr_pkg::*;
#(
    parameter int NREG        = 4,
    parameter bit EL2_PRESENT = 1'b1
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    input  logic [1:0] el,
    input  logic [2:0] nv,
    input  logic       sre_el2,
    input  logic       sre_el3,
    input  logic       is_write,
    output logic       hit,
    output decision_t  dec
);

    logic [1:0] idx;
    logic       idx_ok;

    assign idx    = op2[1:0];
    assign idx_ok = (int'(idx) < NREG);
    assign hit    = (op0 == 2'b11) && (op1 == 3'b100) && (crn == 4'b1100)
                 && (crm == 4'b1000) && (op2[2] == 1'b0);

    always_comb begin
        dec         = '0;
        dec.outcome = OUT_UNDEF;
        if (idx_ok) begin
            unique case (el)
                2'd0: dec.outcome = OUT_UNDEF;
                2'd1: begin
                    if (EL2_PRESENT && nv[2] && nv[0]) begin
                        dec.outcome    = OUT_REDIR;
                        dec.redir_addr = REDIR_BASE + {7'd0, idx, 3'd0};
                    end else if (EL2_PRESENT && nv[0]) begin
                        dec.outcome = OUT_TRAP;
                        dec.trap_el = 2'd2;
                    end
                end
                2'd2: begin
                    if (EL2_PRESENT) begin
                        if (!sre_el2) begin
                            dec.outcome = OUT_TRAP;
                            dec.trap_el = 2'd2;
                        end else begin
                            dec.outcome = OUT_NORMAL;
                            dec.rd_en   = !is_write;
                            dec.wr_en   = is_write;
                        end
                    end
                end
                2'd3: begin
                    if (!sre_el3) begin
                        dec.outcome = OUT_TRAP;
                        dec.trap_el = 2'd3;
                    end else begin
                        dec.outcome = OUT_NORMAL;
                        dec.rd_en   = EL2_PRESENT && !is_write;
                        dec.wr_en   = EL2_PRESENT && is_write;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/vapr_store.sv
module vapr_store
    import vapr_pkg::*;
#(
    parameter int NREG = 4,
    localparam int NBITS = NREG * 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [1:0]       rd_idx,
    output logic [31:0]      rd_data,
    output logic [NBITS-1:0] flat
);

    logic [31:0] bank_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[g] <= '0;
            else if (wr_en && (wr_idx == 2'(g)))
                bank_q[g] <= wr_data;
        end
        assign flat[g*32 +: 32] = bank_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < NREG; g++)
            if (rd_idx == 2'(g)) rd_data = bank_q[g];
    end

    // R2: the decoder never enables a write to a missing index
    assert_wr_idx_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NREG));

endmodule

// File: rtl/vapr_prio_find.sv
module vapr_prio_find #(
    parameter int W = 128,
    localparam int LW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  bits,
    output logic          found,
    output logic [LW-1:0] level
);

    always_comb begin
        found = 1'b0;
        level = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found = 1'b1;
                level = LW'(i);
            end
        end
    end

    // R9: the reported level is set and nothing below it is set
    assert_level_is_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (bits[level] && ((bits & ((W'(1) << level) - W'(1))) == '0)));

endmodule

// File: rtl/vapr_bank.sv
module vapr_bank
    import vapr_pkg::*;
#(
    parameter int PRE_BITS    = 7,
    parameter bit EL2_PRESENT = 1'b1,
    localparam int NREG  = nreg_for(PRE_BITS),
    localparam int NBITS = NREG * 32,
    localparam int LVL_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_op0,
    input  logic [2:0]       req_op1,
    input  logic [3:0]       req_crn,
    input  logic [3:0]       req_crm,
    input  logic [2:0]       req_op2,
    input  logic [1:0]       req_el,
    input  logic [2:0]       req_nv,
    input  logic             sre_el2,
    input  logic             sre_el3,
    input  logic [63:0]      req_wdata,
    output logic             rsp_valid,
    output logic [3:0]       rsp_outcome,
    output logic [63:0]      rsp_rdata,
    output logic [11:0]      rsp_redir_addr,
    output logic [1:0]       rsp_trap_el,
    output logic [5:0]       rsp_class,
    output logic             top_valid,
    output logic [LVL_W-1:0] top_level
);

    state_e           state_q, state_d;
    decision_t        dec;
    logic             hit, accept;
    logic [31:0]      rd_data;
    logic [NBITS-1:0] flat;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^req_wdata[63:32];
    assign accept = req_valid && hit;

    vapr_access_decode #(.NREG(NREG), .EL2_PRESENT(EL2_PRESENT)) u_decode (
        .op0(req_op0), .op1(req_op1), .crn(req_crn), .crm(req_crm), .op2(req_op2),
        .el(req_el), .nv(req_nv), .sre_el2(sre_el2), .sre_el3(sre_el3),
        .is_write(req_write), .hit(hit), .dec(dec)
    );

    vapr_store #(.NREG(NREG)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(accept && dec.wr_en),
        .wr_idx(req_op2[1:0]), .wr_data(req_wdata[31:0]),
        .rd_idx(req_op2[1:0]), .rd_data(rd_data), .flat(flat)
    );

    vapr_prio_find #(.W(NBITS)) u_prio (
        .clk(clk), .rst_n(rst_n), .bits(flat), .found(top_valid), .level(top_level)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = accept ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign rsp_valid = (state_q == ST_RESP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_outcome    <= '0;
            rsp_rdata      <= '0;
            rsp_redir_addr <= '0;
            rsp_trap_el    <= '0;
            rsp_class      <= '0;
        end else if (accept) begin
            rsp_outcome    <= dec.outcome;
            rsp_rdata      <= dec.rd_en ? {32'd0, rd_data} : 64'd0;
            rsp_redir_addr <= dec.redir_addr;
            rsp_trap_el    <= dec.trap_el;
            rsp_class      <= (dec.outcome == OUT_TRAP) ? TRAP_CLASS : 6'd0;
        end
    end

    // R10: exactly one outcome bit on every response
    assert_outcome_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones(rsp_outcome) == 1);
    // R1: reserved half never reads non-zero
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[63:32] == 32'd0);
    // R4: EL0 access is undefined on the next response
    assert_el0_undef_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_el == 2'd0) |=> (rsp_valid && rsp_outcome == OUT_UNDEF));
    // R2: missing index is undefined on the next response
    assert_missing_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && int'(req_op2[1:0]) >= NREG) |=> (rsp_outcome == OUT_UNDEF));
    // R3: no response without a matching request
    assert_no_stray_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid);
    // R6: disabled EL2 access traps to EL2
    assert_el2_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && EL2_PRESENT && req_el == 2'd2 && !sre_el2 && int'(req_op2[1:0]) < NREG)
        |=> (rsp_outcome == OUT_TRAP && rsp_trap_el == 2'd2));
    // R5: redirect addresses stay 8-byte aligned inside the slot window
    assert_redir_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome == OUT_REDIR) |->
        (rsp_redir_addr[2:0] == 3'd0 && rsp_redir_addr >= REDIR_BASE && rsp_redir_addr <= 12'h498));

endmodule

// File: tb/vapr_bank_bench.sv
module vapr_bank_bench;

    typedef struct {
        logic [3:0]  outcome;
        logic [63:0] rdata;
        logic [11:0] addr;
        logic [1:0]  trap_el;
        logic [5:0]  cls;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_write, sre_el2, sre_el3;
    logic [1:0]  req_op0, req_el;
    logic [2:0]  req_op1, req_op2, req_nv;
    logic [3:0]  req_crn, req_crm;
    logic [63:0] req_wdata;
    logic        va_valid = 1'b0, vb_valid = 1'b0;

    logic        a_rv, a_tv, b_rv, b_tv;
    logic [3:0]  a_out, b_out;
    logic [63:0] a_rd, b_rd;
    logic [11:0] a_ad, b_ad;
    logic [1:0]  a_te, b_te;
    logic [5:0]  a_cl, b_cl;
    logic [6:0]  a_lv;
    logic [4:0]  b_lv;

    vapr_bank #(.PRE_BITS(7), .EL2_PRESENT(1'b1)) u_vapr_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(va_valid), .req_write(req_write),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_el(req_el), .req_nv(req_nv), .sre_el2(sre_el2),
        .sre_el3(sre_el3), .req_wdata(req_wdata), .rsp_valid(a_rv), .rsp_outcome(a_out),
        .rsp_rdata(a_rd), .rsp_redir_addr(a_ad), .rsp_trap_el(a_te), .rsp_class(a_cl),
        .top_valid(a_tv), .top_level(a_lv));

    vapr_bank #(.PRE_BITS(5), .EL2_PRESENT(1'b0)) u_vapr_bank_small (
        .clk(clk), .rst_n(rst_n), .req_valid(vb_valid), .req_write(req_write),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_el(req_el), .req_nv(req_nv), .sre_el2(sre_el2),
        .sre_el3(sre_el3), .req_wdata(req_wdata), .rsp_valid(b_rv), .rsp_outcome(b_out),
        .rsp_rdata(b_rd), .rsp_redir_addr(b_ad), .rsp_trap_el(b_te), .rsp_class(b_cl),
        .top_valid(b_tv), .top_level(b_lv));

    int   n_checks = 0, n_fail = 0;
    exp_t q_a[$], q_b[$];
    logic [31:0] shadow [4] = '{default: 32'd0};

    // Expected result from the requirements; inst 0 = 7 bits with EL2, 1 = 5 bits without
    function automatic exp_t model(input int inst, input logic wr, input logic [1:0] el,
                                   input logic [2:0] nv, input logic s2, input logic s3,
                                   input logic [1:0] m, input logic [63:0] wd, input string tag);
        exp_t e;
        int   nreg = (inst == 0) ? 4 : 1;
        bit   el2  = (inst == 0);
        e = '{outcome: 4'b1000, rdata: 64'd0, addr: 12'd0, trap_el: 2'd0, cls: 6'd0, tag: tag};
        if (int'(m) >= nreg) return e;
        if (el == 2'd1 && el2) begin
            if (nv[2] && nv[0]) begin e.outcome = 4'b0010; e.addr = 12'h480 + 12'(8 * int'(m)); end
            else if (nv[0]) begin e.outcome = 4'b0100; e.trap_el = 2'd2; e.cls = 6'h18; end
        end else if ((el == 2'd2 && el2) || el == 2'd3) begin
            if ((el == 2'd2 && !s2) || (el == 2'd3 && !s3)) begin
                e.outcome = 4'b0100; e.trap_el = el; e.cls = 6'h18;
            end else begin
                e.outcome = 4'b0001;
                if (el2) begin
                    if (wr) shadow[m] = wd[31:0];
                    else    e.rdata = {32'd0, shadow[m]};
                end
            end
        end
        return e;
    endfunction

    task automatic set_enc(input logic [2:0] op2);
        req_op0 = 2'b11; req_op1 = 3'b100; req_crn = 4'b1100; req_crm = 4'b1000; req_op2 = op2;
    endtask

    task automatic apply(input int inst, input logic wr, input logic [1:0] el, input logic [2:0] nv,
                         input logic s2, input logic s3, input logic [1:0] m,
                         input logic [63:0] wd, input string tag);
        @(negedge clk);
        set_enc({1'b0, m});
        req_write = wr; req_el = el; req_nv = nv; sre_el2 = s2; sre_el3 = s3; req_wdata = wd;
        if (inst == 0) begin va_valid = 1'b1; q_a.push_back(model(0, wr, el, nv, s2, s3, m, wd, tag)); end
        else           begin vb_valid = 1'b1; q_b.push_back(model(1, wr, el, nv, s2, s3, m, wd, tag)); end
        @(negedge clk);
        va_valid = 1'b0; vb_valid = 1'b0;
    endtask

    task automatic compare(input exp_t e, input logic [3:0] o, input logic [63:0] d,
                           input logic [11:0] a, input logic [1:0] t, input logic [5:0] c);
        n_checks++;
        if (o !== e.outcome || d !== e.rdata || a !== e.addr || t !== e.trap_el || c !== e.cls) begin
            n_fail++;
            $display("FAIL %s: got out=%b data=%h addr=%h el=%0d cls=%h exp out=%b data=%h addr=%h el=%0d cls=%h",
                     e.tag, o, d, a, t, c, e.outcome, e.rdata, e.addr, e.trap_el, e.cls);
        end
    endtask

    // Monitor: pops one expectation per response
    always @(negedge clk) begin
        if (rst_n && a_rv) begin
            if (q_a.size() == 0) begin n_checks++; n_fail++; $display("FAIL R3: unexpected response A out=%b exp none", a_out); end
            else compare(q_a.pop_front(), a_out, a_rd, a_ad, a_te, a_cl);
        end
        if (rst_n && b_rv) begin
            if (q_b.size() == 0) begin n_checks++; n_fail++; $display("FAIL R3: unexpected response B out=%b exp none", b_out); end
            else compare(q_b.pop_front(), b_out, b_rd, b_ad, b_te, b_cl);
        end
    end

    task automatic check_top(input int inst, input logic ev, input int el_exp, input string tag);
        logic v; int l;
        @(negedge clk);
        v = (inst == 0) ? a_tv : b_tv;
        l = (inst == 0) ? int'(a_lv) : int'(b_lv);
        n_checks++;
        if (v !== ev || (ev && l != el_exp)) begin
            n_fail++;
            $display("FAIL %s: top valid=%b level=%0d exp valid=%b level=%0d", tag, v, l, ev, el_exp);
        end
    endtask

    task automatic bad_enc(input int field, input string tag);
        @(negedge clk);
        set_enc(3'b000); req_write = 1'b1; req_el = 2'd2; sre_el2 = 1'b1; sre_el3 = 1'b1;
        req_wdata = 64'hFFFF_FFFF;
        if (field == 0) req_op0 = 2'b10;
        else if (field == 1) req_crm = 4'b1001;
        else req_op2 = 3'b100;
        va_valid = 1'b1;
        @(negedge clk);
        va_valid = 1'b0;
        n_checks++;
        if (a_rv !== 1'b0) begin n_fail++; $display("FAIL %s: rsp_valid=%b exp 0", tag, a_rv); end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run hung, exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        set_enc(3'b000); req_write = 0; req_el = 0; req_nv = 0; sre_el2 = 1; sre_el3 = 1; req_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        check_top(0, 1'b0, 0, "R8 reset top A");
        for (int m = 0; m < 4; m++) apply(0, 0, 2'd2, 3'd0, 1, 1, 2'(m), 64'd0, "R8 reset read");
        // R1: upper half dropped
        apply(0, 1, 2'd2, 3'd0, 1, 1, 2'd0, 64'hFFFF_0000_8000_0010, "R1 write idx0");
        apply(0, 0, 2'd2, 3'd0, 1, 1, 2'd0, 64'd0, "R1 read idx0");
        check_top(0, 1'b1, 4, "R9 lowest bit 4");
        // R9: search across registers
        apply(0, 1, 2'd3, 3'd0, 1, 1, 2'd2, 64'h1, "R6 EL3 write idx2");
        check_top(0, 1'b1, 4, "R9 still 4");
        apply(0, 1, 2'd2, 3'd0, 1, 1, 2'd0, 64'h0, "R9 clear idx0");
        check_top(0, 1'b1, 64, "R9 level 64");
        apply(0, 1, 2'd2, 3'd0, 1, 1, 2'd3, 64'h8000_0000, "R9 write idx3");
        apply(0, 1, 2'd2, 3'd0, 1, 1, 2'd2, 64'h0, "R9 clear idx2");
        check_top(0, 1'b1, 127, "R9 level 127");
        // R4
        apply(0, 0, 2'd0, 3'd5, 1, 1, 2'd1, 64'd0, "R4 EL0 undef");
        // R5: EL1 routing, redirect write leaves bank alone
        apply(0, 1, 2'd1, 3'b101, 1, 1, 2'd3, 64'h1234, "R5 redirect idx3");
        apply(0, 0, 2'd1, 3'b111, 1, 1, 2'd1, 64'd0, "R5 redirect idx1");
        apply(0, 0, 2'd1, 3'b001, 1, 1, 2'd0, 64'd0, "R5 trap EL2");
        apply(0, 0, 2'd1, 3'b100, 1, 1, 2'd0, 64'd0, "R5 nv100 undef");
        apply(0, 0, 2'd1, 3'b000, 1, 1, 2'd0, 64'd0, "R5 nv000 undef");
        apply(0, 0, 2'd2, 3'd0, 1, 1, 2'd3, 64'd0, "R5 redirect left idx3");
        // R6: disabled levels trap, write dropped
        apply(0, 1, 2'd2, 3'd0, 0, 1, 2'd3, 64'h0, "R6 EL2 trap write");
        apply(0, 0, 2'd3, 3'd0, 1, 0, 2'd3, 64'd0, "R6 EL3 trap");
        apply(0, 0, 2'd3, 3'd0, 1, 1, 2'd3, 64'd0, "R6 trapped write left idx3");
        check_top(0, 1'b1, 127, "R6 top unchanged");
        // R3: foreign encodings
        bad_enc(0, "R3 op0 mismatch");
        bad_enc(1, "R3 CRm mismatch");
        bad_enc(2, "R3 op2[2] set");
        check_top(0, 1'b1, 127, "R3 no write from foreign encoding");
        // R2, R7: small build without EL2
        apply(1, 1, 2'd3, 3'd0, 1, 1, 2'd1, 64'h1, "R2 idx1 missing");
        apply(1, 0, 2'd3, 3'd0, 1, 1, 2'd3, 64'd0, "R2 idx3 missing");
        apply(1, 0, 2'd2, 3'd0, 1, 1, 2'd0, 64'd0, "R6 EL2 absent undef");
        apply(1, 0, 2'd1, 3'b101, 1, 1, 2'd0, 64'd0, "R5 EL1 without EL2 undef");
        apply(1, 1, 2'd3, 3'd0, 1, 1, 2'd0, 64'hFF, "R7 EL3 write ignored");
        apply(1, 0, 2'd3, 3'd0, 1, 1, 2'd0, 64'd0, "R7 EL3 reads zero");
        check_top(1, 1'b0, 0, "R7 top stays clear");
        apply(1, 0, 2'd3, 3'd0, 1, 0, 2'd0, 64'd0, "R10 trap fields");
        repeat (3) @(negedge clk);
        n_checks++;
        if (q_a.size() != 0 || q_b.size() != 0) begin
            n_fail++;
            $display("FAIL R10: missing responses A=%0d B=%0d exp 0", q_a.size(), q_b.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule